// File: doc/BRIEF.md
# Parallel-Port Peripheral Bus Interface

A small register file for a 6502-style synchronous bus that drives two 8-bit parallel ports. Each port has an output register and a direction register. A direction bit set to 1 makes the matching pin an output. The bus side has a phase-2 strobe (`phi2`), an active-high chip select, a read/write line (1 = read) and a 2-bit register select. All of these are sampled on the fabric clock `clk`.

A write is latched in two steps. While `phi2` is high, the bus data is captured every clock. The target register is then updated only in the clock cycle in which `phi2` is seen falling, and only if chip select is high and R/W is low in that cycle. Releasing chip select does not commit anything. A bus access that raises `phi2` and holds it high stays pending for as long as `phi2` stays high. It completes at the next fall of `phi2`.

Reads drive the shared data bus only while chip select is high, R/W is high and `phi2` is high. At all other times the bus is left at high impedance. A port read returns the output register on pins configured as outputs and the external pin level on pins configured as inputs.

Top module: `pio_bus_regs`

## Requirements
- R1: After reset, all four registers read 0, every `*_oe` and `*_out` bit is 0, and a port read returns its external pins.
- R2: Register select 0 addresses the port B output register, 1 the port A output register, 2 the port B direction register and 3 the port A direction register. A write to each one lands in that register only.
- R3: While `phi2` stays high, no register changes, however many clocks pass. A pending write takes effect in the clock edge that follows the first low sample of `phi2`.
- R4: A write whose chip select is low in the cycle `phi2` falls is discarded, even when chip select was high while `phi2` was high.
- R5: A bus access with R/W high when `phi2` falls leaves every register unchanged.
- R6: The committed byte is the bus value of the last clock with `phi2` high. A bus change in the cycle `phi2` falls is ignored.
- R7: The block drives `bus_d` only when `cs`, `rw` and `phi2` are all high. Otherwise the bus carries what the other side drives.
- R8: A read of select 2 or 3 returns the direction register. A read of select 0 or 1 returns `(dir & out_reg) | (~dir & pins)` for that port.
- R9: `pX_oe` equals the port's direction register, and `pX_out` equals the output register masked by the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples all bus inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Bus phase-2 strobe |
| cs | input | 1 | Chip select from address decode, active high |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 2 | Register select |
| bus_d | inout | 8 | Bidirectional data bus |
| pa_pins | input | 8 | External level of port A pins |
| pb_pins | input | 8 | External level of port B pins |
| pa_out | output | 8 | Port A output value, masked by direction |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_out | output | 8 | Port B output value, masked by direction |
| pb_oe | output | 8 | Port B per-bit output enable |

## Verification
The hardest case is the stalled transaction. In it `phi2` is raised and then held high for several clocks, and chip select or the bus data may change before the fall. The stimulus splits each write into a start step and a finish step, so several clocks can be placed between them. During that gap the bench checks that the port enables have not moved. The finish step can drop chip select and corrupt the bus in the same cycle that `phi2` falls.

// File: rtl/pio_bus_regs.sv
module pio_bus_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phi2,
  input  logic         cs,
  input  logic         rw,
  input  logic [1:0]   rs,
  inout  wire  [W-1:0] bus_d,
  input  logic [W-1:0] pa_pins,
  input  logic [W-1:0] pb_pins,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe
);
  localparam int NREG = 4;
  localparam int OUTB = 0;
  localparam int OUTA = 1;
  localparam int DIRB = 2;
  localparam int DIRA = 3;

  logic [W-1:0] regs [NREG];
  logic [W-1:0] wdata_q;
  logic [W-1:0] rd_data;
  logic         phi2_q;

  wire fall   = phi2_q & ~phi2;
  wire commit = fall & cs & ~rw;
  wire rd_en  = cs & rw & phi2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi2_q  <= 1'b0;
      wdata_q <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      phi2_q <= phi2;
      if (phi2) wdata_q <= bus_d;
      if (commit) regs[rs] <= wdata_q;
    end
  end

  assign pb_oe  = regs[DIRB];
  assign pa_oe  = regs[DIRA];
  assign pb_out = regs[OUTB] & regs[DIRB];
  assign pa_out = regs[OUTA] & regs[DIRA];

  always_comb begin
    case (rs)
      2'd0:    rd_data = pb_out | (pb_pins & ~regs[DIRB]);
      2'd1:    rd_data = pa_out | (pa_pins & ~regs[DIRA]);
      2'd2:    rd_data = regs[DIRB];
      default: rd_data = regs[DIRA];
    endcase
  end

  assign bus_d = rd_en ? rd_data : {W{1'bz}};

  // R3
  hold_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> ($stable(regs[0]) && $stable(regs[1]) && $stable(regs[2]) && $stable(regs[3])));

  // R5
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && rw) |=> ($stable(regs[0]) && $stable(regs[1]) && $stable(regs[2]) && $stable(regs[3])));

  // R8
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rs[1]) |-> (bus_d == (rs[0] ? regs[DIRA] : regs[DIRB])));

  for (genvar g = 0; g < NREG; g++) begin : g_commit
    // R2
    commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && cs && !rw && rs == g) |=> (regs[g] == $past(wdata_q)));
  end
endmodule

// File: tb/pio_bus_regs_bench.sv
module pio_bus_regs_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic phi2 = 0, cs = 0, rw = 1;
  logic [1:0] rs = 0;
  logic drv = 0;
  logic [7:0] dv = 0;
  logic [7:0] pa_pins = 8'h96, pb_pins = 8'h3C;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
  wire  [7:0] bus_d;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m [4];

  assign bus_d = drv ? dv : 8'hzz;
  always #2 clk = ~clk;

  pio_bus_regs u_pio_bus_regs (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cs(cs), .rw(rw), .rs(rs),
    .bus_d(bus_d), .pa_pins(pa_pins), .pb_pins(pb_pins),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_begin(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); cs = 1; rw = 0; rs = a; drv = 1; dv = v; phi2 = 0;
    @(negedge clk); phi2 = 1;
  endtask

  task automatic wr_end(input bit keep_cs);
    @(negedge clk); phi2 = 0; dv = ~dv; cs = keep_cs;
    @(negedge clk); cs = 0; drv = 0; rw = 1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); cs = 1; rw = 1; rs = a; drv = 0; phi2 = 1;
    #1 v = bus_d;
    @(negedge clk); phi2 = 0; cs = 0;
  endtask

  function automatic logic [7:0] port_exp(input int p);
    if (p == 0) return (m[2] & m[0]) | (~m[2] & pb_pins);
    return (m[3] & m[1]) | (~m[3] & pa_pins);
  endfunction

  task automatic chk_pins(input string req);
    chk(req, pb_oe, m[2]);
    chk(req, pa_oe, m[3]);
    chk(req, pb_out, m[0] & m[2]);
    chk(req, pa_out, m[1] & m[3]);
  endtask

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 4; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_pins("R1");
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r);
      chk("R1", r, a == 0 ? pb_pins : (a == 1 ? pa_pins : 8'h00));
    end
    // R2 R8 R9 sweep over every register and a spread of values
    for (int a = 0; a < 4; a++) begin
      for (int v = 0; v < 256; v += 17) begin
        wr_begin(a[1:0], v[7:0]);
        wr_end(1);
        m[a] = v[7:0];
        chk_pins("R9");
        for (int b = 0; b < 4; b++) begin
          rd(b[1:0], r);
          chk(b < 2 ? "R8" : "R2", r, b < 2 ? port_exp(b) : m[b]);
        end
      end
    end
    // R8 port readback against changing pins
    for (int k = 0; k < 8; k++) begin
      pa_pins = 8'h01 << k; pb_pins = ~(8'h80 >> k);
      rd(2'd0, r); chk("R8", r, port_exp(0));
      rd(2'd1, r); chk("R8", r, port_exp(1));
    end
    // R3 stalled write
    for (int n = 1; n < 7; n++) begin
      wr_begin(2'd2, 8'hC3 ^ n[7:0]);
      repeat (n) begin
        @(negedge clk);
        chk("R3", pb_oe, m[2]);
      end
      wr_end(1);
      m[2] = 8'hC3 ^ n[7:0];
      chk("R3", pb_oe, m[2]);
    end
    // R4 chip select dropped before fall
    wr_begin(2'd3, ~m[3]);
    repeat (3) @(negedge clk);
    wr_end(0);
    chk("R4", pa_oe, m[3]);
    // R6 data from last high cycle, bus change at fall ignored
    wr_begin(2'd1, 8'h11);
    @(negedge clk); dv = 8'h7E;
    wr_end(1);
    m[1] = 8'h7E;
    chk_pins("R6");
    // R5 reads at fall do not write
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); cs = 1; rw = 1; rs = a[1:0]; drv = 0; phi2 = 1;
      @(negedge clk); phi2 = 0;
      @(negedge clk); cs = 0;
      chk_pins("R5");
    end
    // R7 no drive unless cs, rw and phi2 are all high
    @(negedge clk); cs = 0; rw = 1; phi2 = 1; drv = 1; dv = 8'h5A;
    #1 chk("R7", bus_d, 8'h5A);
    @(negedge clk); cs = 1; rw = 1; phi2 = 0; dv = 8'hA6;
    #1 chk("R7", bus_d, 8'hA6);
    @(negedge clk); cs = 1; rw = 0; phi2 = 1; dv = 8'h3B;
    #1 chk("R7", bus_d, 8'h3B);
    @(negedge clk); phi2 = 0; cs = 0; rw = 1; drv = 0;
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule